// File: doc/BRIEF.md
# Fuse Array Command Front-End

This block sits between a CPU register port and a one-time-programmable fuse array. Software sees a small bank of registers. It turns on CPU access, loads a row index and a 41-bit data word (32 data bits and 9 check bits), and launches commands by raising a start bit. It then polls a completion flag, which it clears by writing a one to it. The fuse array is modelled inside the block as a bank of 41-bit rows. Every row starts at zero, and programming can only set bits.

Programming is guarded. A program-word command changes nothing until software has sent an exact ordered run of four program-enable commands, each carrying its own key value. Any other command, or a wrong key, drops the progress made so far. A read places the row in two read-data registers. When checking is on, it raises an error flag if the row fails a placeholder integrity test (odd parity over all 41 bits). Commands run only after a fixed settling delay that follows reset, and each command takes a fixed number of cycles.

Top module: `fuse_cmd_frontend`

## Requirements
- R1: After reset every software-visible register reads zero, including both status registers and both read-data registers.
- R2: Status0 bit 3 (settled) is 0 until INIT_CYCLES clock cycles after reset is released, then goes to 1 and stays at 1.
- R3: A command starts only on a 0-to-1 change of bit 0 of the command register (offset 0x10, code in bits 4:1), and only while program-control bit 15 (CPU access) is 1, status0 bit 3 is 1 and no command is running. In any other case nothing runs and the done flag stays 0.
- R4: Status1 bit 1 (done) becomes 1 exactly CMD_CYCLES+1 clock edges after the edge that writes the start bit. Writing 1 to status1 bit 1 clears it. Writing 0 to that bit leaves it set.
- R5: A read command (code 0) takes the row selected by address-register bits 15:6. It returns data bits 31:0 at offset 0x20 and check bits 40:32 in bits 8:0 at offset 0x24.
- R6: After a read, status1 bit 17 is 1 exactly when program-control bit 9 (check disable) was 0 and the 41-bit row has odd parity.
- R7: Status0 bit 2 (unlocked) rises only after four program-enable commands (code 2) in a row whose write-data-low values are 0xF, 0x4, 0x8 and 0xD, in that order.
- R8: A program-enable command with the wrong key, or any command other than program-word, resets the sequence progress and clears the unlocked flag.
- R9: A program-word command (code 10) that runs while unlocked ORs write-data-low into row bits 31:0. It ORs write-data-high bits 8:0 into row bits 40:32 only if program-control bit 8 is 1. The unlocked flag stays set.
- R10: A program-word command that runs while locked leaves every row unchanged.
- R11: Only the implemented bits read back: program control bits 15, 9 and 8 (offset 0x00), write-data-low all 32 bits (0x04), write-data-high bits 8:0 (0x08), address bits 15:6 (0x0C) and command bits 4:0 (0x10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register at reg_addr, combinational |

## Verification
The bench goes after the gates on the start edge. A start written before the settling delay ends, or while CPU access is off, must run nothing; a design that latches the start level instead of the edge would run the command late and set done. The unlock chain is tested with a wrong third key and with a read inserted before the last key. A tracker that does not reset its step would then unlock early, and a row written afterwards would show the extra bits. A full sweep reads every row after overlapping programs, with check-bit writing both on and off. This exposes a write that overwrites instead of ORing, check bits stored without their enable, and a parity flag that ignores the check-disable bit.

// File: rtl/fuse_pkg.sv
// Shared constants for the fuse command front-end: register offsets,
// command codes, control bit positions and the unlock key sequence.
package fuse_pkg;
    localparam logic [7:0] OFS_PCTL  = 8'h00;
    localparam logic [7:0] OFS_WLO   = 8'h04;
    localparam logic [7:0] OFS_WHI   = 8'h08;
    localparam logic [7:0] OFS_ADDR  = 8'h0C;
    localparam logic [7:0] OFS_CMD   = 8'h10;
    localparam logic [7:0] OFS_STAT0 = 8'h18;
    localparam logic [7:0] OFS_STAT1 = 8'h1C;
    localparam logic [7:0] OFS_RLO   = 8'h20;
    localparam logic [7:0] OFS_RHI   = 8'h24;

    localparam int BIT_CPU_EN  = 15;
    localparam int BIT_CHK_OFF = 9;
    localparam int BIT_ECC_WR  = 8;
    localparam int ROW_LSB     = 6;

    localparam int DATA_W  = 32;
    localparam int CHECK_W = 9;
    localparam int ROW_W   = DATA_W + CHECK_W;

    localparam logic [3:0] CODE_READ = 4'd0;
    localparam logic [3:0] CODE_PEN  = 4'd2;
    localparam logic [3:0] CODE_PWR  = 4'd10;

    // Key expected at each step of the unlock run.
    function automatic logic [31:0] unlock_key(input logic [1:0] step);
        case (step)
            2'd0:    unlock_key = 32'h0000_000F;
            2'd1:    unlock_key = 32'h0000_0004;
            2'd2:    unlock_key = 32'h0000_0008;
            default: unlock_key = 32'h0000_000D;
        endcase
    endfunction
endpackage

// File: rtl/fuse_init_timer.sv
// Settling timer: raises init_done INIT_CYCLES cycles after reset release.
// Assumes INIT_CYCLES >= 1; the flag holds until the next reset.
module fuse_init_timer #(
    parameter int INIT_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic init_done
);
    localparam int CW = $clog2(INIT_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Count up after reset and set the flag on the last count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            init_done <= 1'b0;
        end else if (!init_done) begin
            if (cnt == CW'(INIT_CYCLES - 1)) init_done <= 1'b1;
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_done) |-> init_done);
endmodule

// File: rtl/fuse_unlock.sv
// Unlock tracker: follows completed commands and raises unlocked after the
// four program-enable keys in order. Assumes evt is a one-cycle pulse.
module fuse_unlock
    import fuse_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        evt,
    input  logic        is_pe,
    input  logic        is_pw,
    input  logic [31:0] key,
    output logic        unlocked
);
    logic [1:0] step;
    logic       key_ok;

    assign key_ok = (key == unlock_key(step));

    // Advance on a correct key, restart on anything but program-word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step     <= 2'd0;
            unlocked <= 1'b0;
        end else if (evt && !is_pw) begin
            if (is_pe && key_ok) begin
                step     <= step + 2'd1;
                unlocked <= (step == 2'd3);
            end else begin
                step     <= 2'd0;
                unlocked <= 1'b0;
            end
        end
    end

    // R7
    unlock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(evt && is_pe && step == 2'd3 && key == 32'hD));
    // R8
    unlock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !is_pe && !is_pw) |=> (!unlocked && step == 2'd0));
endmodule

// File: rtl/fuse_array.sv
// Fuse storage model: ROWS rows that start at zero and only gain ones.
// Read is combinational on rd_row; write ORs wr_bits into wr_row.
module fuse_array #(
    parameter int ROWS  = 1024,
    parameter int ROW_W = 41,
    localparam int AW   = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_row,
    input  logic [ROW_W-1:0] wr_bits,
    input  logic [AW-1:0]    rd_row,
    output logic [ROW_W-1:0] rd_bits
);
    logic [ROW_W-1:0] mem [ROWS];

    // Clear the model on reset; OR new ones into the row on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ROWS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_row] <= mem[wr_row] | wr_bits;
        end
    end

    // Read port.
    assign rd_bits = mem[rd_row];
endmodule

// File: rtl/fuse_cmd_frontend.sv
// Register front-end for the fuse array: decodes the register port,
// gates command starts, times each command and runs it on completion.
// Assumes one register access per cycle and CMD_CYCLES >= 1.
module fuse_cmd_frontend
    import fuse_pkg::*;
#(
    parameter int ROWS        = 1024,
    parameter int INIT_CYCLES = 64,
    parameter int CMD_CYCLES  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_valid,
    input  logic        reg_write,
    input  logic [7:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata
);
    localparam int AW = $clog2(ROWS);
    localparam int BW = $clog2(CMD_CYCLES + 1);

    logic               cpu_en, chk_off, ecc_wr;
    logic [31:0]        wlo;
    logic [CHECK_W-1:0] whi;
    logic [AW-1:0]      row_sel;
    logic               start, start_q;
    logic [3:0]         code;
    logic [BW-1:0]      busy;
    logic [3:0]         op_code;
    logic [AW-1:0]      op_row;
    logic [ROW_W-1:0]   op_data;
    logic               op_ecc_wr, op_chk;
    logic               done, ecc_err;
    logic [31:0]        rlo;
    logic [CHECK_W-1:0] rhi;
    logic               init_done, unlocked, wr, fire, complete;
    logic [ROW_W-1:0]   rd_bits, wr_bits;

    assign wr       = reg_valid && reg_write;
    assign fire     = start && !start_q && cpu_en && init_done && (busy == '0);
    assign complete = (busy == BW'(1));
    assign wr_bits  = {op_ecc_wr ? op_data[ROW_W-1:DATA_W] : {CHECK_W{1'b0}},
                       op_data[DATA_W-1:0]};

    fuse_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .init_done(init_done));

    fuse_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .evt(complete),
        .is_pe(op_code == CODE_PEN), .is_pw(op_code == CODE_PWR),
        .key(op_data[DATA_W-1:0]), .unlocked(unlocked));

    fuse_array #(.ROWS(ROWS), .ROW_W(ROW_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_en(complete && op_code == CODE_PWR && unlocked),
        .wr_row(op_row), .wr_bits(wr_bits),
        .rd_row(op_row), .rd_bits(rd_bits));

    // Software-written control, data, address and command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_en <= 1'b0; chk_off <= 1'b0; ecc_wr <= 1'b0;
            wlo <= '0; whi <= '0; row_sel <= '0; start <= 1'b0; code <= '0;
        end else if (wr) begin
            case (reg_addr)
                OFS_PCTL: begin
                    cpu_en  <= reg_wdata[BIT_CPU_EN];
                    chk_off <= reg_wdata[BIT_CHK_OFF];
                    ecc_wr  <= reg_wdata[BIT_ECC_WR];
                end
                OFS_WLO:  wlo     <= reg_wdata;
                OFS_WHI:  whi     <= reg_wdata[CHECK_W-1:0];
                OFS_ADDR: row_sel <= reg_wdata[ROW_LSB +: AW];
                OFS_CMD: begin
                    start <= reg_wdata[0];
                    code  <= reg_wdata[4:1];
                end
                default: ;
            endcase
        end
    end

    // Delay of the start bit for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b0;
        else        start_q <= start;
    end

    // Command timer and operand capture at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= '0; op_code <= '0; op_row <= '0; op_data <= '0;
            op_ecc_wr <= 1'b0; op_chk <= 1'b0;
        end else if (fire) begin
            busy      <= BW'(CMD_CYCLES);
            op_code   <= code;
            op_row    <= row_sel;
            op_data   <= {whi, wlo};
            op_ecc_wr <= ecc_wr;
            op_chk    <= !chk_off;
        end else if (busy != '0) begin
            busy <= busy - 1'b1;
        end
    end

    // Done flag: set on completion, cleared by writing one to it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                        done <= 1'b0;
        else if (complete)                                 done <= 1'b1;
        else if (wr && reg_addr == OFS_STAT1 && reg_wdata[1]) done <= 1'b0;
    end

    // Read results and integrity flag, captured when a read completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rlo <= '0; rhi <= '0; ecc_err <= 1'b0;
        end else if (complete && op_code == CODE_READ) begin
            rlo     <= rd_bits[DATA_W-1:0];
            rhi     <= rd_bits[ROW_W-1:DATA_W];
            ecc_err <= op_chk && (^rd_bits);
        end
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_PCTL: begin
                reg_rdata[BIT_CPU_EN]  = cpu_en;
                reg_rdata[BIT_CHK_OFF] = chk_off;
                reg_rdata[BIT_ECC_WR]  = ecc_wr;
            end
            OFS_WLO:   reg_rdata = wlo;
            OFS_WHI:   reg_rdata[CHECK_W-1:0] = whi;
            OFS_ADDR:  reg_rdata[ROW_LSB +: AW] = row_sel;
            OFS_CMD:   reg_rdata[4:0] = {code, start};
            OFS_STAT0: begin
                reg_rdata[3] = init_done;
                reg_rdata[2] = unlocked;
            end
            OFS_STAT1: begin
                reg_rdata[17] = ecc_err;
                reg_rdata[1]  = done;
            end
            OFS_RLO:   reg_rdata = rlo;
            OFS_RHI:   reg_rdata[CHECK_W-1:0] = rhi;
            default:   ;
        endcase
    end

    // R3
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !start_q && busy == '0 && !(cpu_en && init_done)) |=> busy == '0);
    // R4
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy) == BW'(1));
    // R10
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy == BW'(1) && op_code == CODE_PWR && !unlocked) |=> $stable(rd_bits));
endmodule

// File: tb/fuse_cmd_frontend_test.sv
// Bench for the fuse front-end: gating, timing, unlock runs, and a full
// sweep of every row against a model computed from the requirements.
module fuse_cmd_frontend_test;
    localparam int ROWS = 1024;
    localparam int INIT = 8;
    localparam int CMDC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [40:0] model [ROWS];

    fuse_cmd_frontend #(.ROWS(ROWS), .INIT_CYCLES(INIT), .CMD_CYCLES(CMDC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Launch a command, wait for done, clear it and drop the start bit.
    task automatic run_cmd(input logic [3:0] c, output int lat);
        logic [31:0] s;
        wr(8'h10, {27'd0, c, 1'b1});
        lat = 0;
        rd(8'h1C, s);
        while (!s[1] && lat < 60) begin
            @(negedge clk);
            lat++;
            rd(8'h1C, s);
        end
        wr(8'h1C, 32'h2);
        wr(8'h10, {27'd0, c, 1'b0});
    endtask

    task automatic set_row(input int r);
        wr(8'h0C, 32'(r) << 6);
    endtask

    task automatic pen(input logic [31:0] k);
        int l;
        wr(8'h04, k);
        run_cmd(4'd2, l);
    endtask

    task automatic read_row(input int r, output logic [40:0] v, output logic e);
        int l;
        logic [31:0] a, b, s;
        set_row(r);
        run_cmd(4'd0, l);
        rd(8'h20, a); rd(8'h24, b); rd(8'h1C, s);
        v = {b[8:0], a};
        e = s[17];
    endtask

    task automatic prog(input int r, input logic [31:0] lo, input logic [8:0] hi,
                        input bit ew, input bit live);
        int l;
        wr(8'h00, ew ? 32'h8100 : 32'h8000);
        set_row(r);
        wr(8'h04, lo);
        wr(8'h08, {23'd0, hi});
        run_cmd(4'd10, l);
        if (live) model[r] = model[r] | {ew ? hi : 9'd0, lo};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [40:0] v;
        logic e;
        int lat;
        for (int i = 0; i < ROWS; i++) model[i] = '0;

        repeat (4) @(posedge clk);
        // R1: every register reads zero in reset
        for (int a = 0; a <= 'h24; a += 4) begin
            rd(8'(a), d);
            chk($sformatf("R1 reg %02h", a), d, 0);
        end
        @(negedge clk); rst_n = 1'b1;
        // R2: not settled straight after release
        rd(8'h18, d); chk("R2 early", d[3], 0);
        // R3: start before settling is ignored
        wr(8'h00, 32'h8000);
        wr(8'h10, 32'h1);
        repeat (INIT + 6) @(negedge clk);
        rd(8'h18, d); chk("R2 settled", d[3], 1);
        rd(8'h1C, d); chk("R3 start before settle", d[1], 0);
        wr(8'h10, 32'h0);

        // R11: implemented bits read back
        wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, d); chk("R11 pctl", d, 32'h8300);
        wr(8'h04, 32'hA5A5_0F0F); rd(8'h04, d); chk("R11 wlo", d, 32'hA5A5_0F0F);
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h08, d); chk("R11 whi", d, 32'h1FF);
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, d); chk("R11 addr", d, 32'hFFC0);
        wr(8'h10, 32'hFFFF_FFFE); rd(8'h10, d); chk("R11 cmd", d, 32'h1E);
        wr(8'h10, 32'h0);

        // R3: start with CPU access off is ignored
        wr(8'h00, 32'h0);
        wr(8'h10, 32'h1);
        repeat (10) @(negedge clk);
        rd(8'h1C, d); chk("R3 cpu off", d[1], 0);
        wr(8'h10, 32'h0);

        // R4: latency and write-one-to-clear; R10 locked program
        wr(8'h00, 32'h8000);
        set_row(5);
        wr(8'h04, 32'h0000_FFFF);
        wr(8'h10, {27'd0, 4'd10, 1'b1});
        lat = 0; rd(8'h1C, d);
        while (!d[1] && lat < 60) begin @(negedge clk); lat++; rd(8'h1C, d); end
        chk("R4 latency", lat, CMDC + 1);
        wr(8'h1C, 32'h0); rd(8'h1C, d); chk("R4 write zero keeps", d[1], 1);
        wr(8'h1C, 32'h2); rd(8'h1C, d); chk("R4 write one clears", d[1], 0);
        wr(8'h10, {27'd0, 4'd10, 1'b0});
        read_row(5, v, e); chk("R10 locked program", v, 0);

        // R8: wrong third key, then a read before the last key
        pen(32'hF); pen(32'h4); pen(32'h9); pen(32'hD);
        rd(8'h18, d); chk("R8 wrong key", d[2], 0);
        pen(32'hF); pen(32'h4); pen(32'h8);
        rd(8'h18, d); chk("R7 three keys not enough", d[2], 0);
        read_row(0, v, e);
        pen(32'hD);
        rd(8'h18, d); chk("R8 interrupted run", d[2], 0);
        prog(7, 32'hFFFF_FFFF, 9'h1FF, 1'b1, 1'b0);
        read_row(7, v, e); chk("R10 after failed unlock", v, 0);

        // R7: full run unlocks
        wr(8'h00, 32'h8000);
        pen(32'hF); pen(32'h4); pen(32'h8); pen(32'hD);
        rd(8'h18, d); chk("R7 unlocked", d[2], 1);

        // R9: overlapping programs with check-bit writing on and off
        for (int i = 0; i < 24; i++) begin
            prog((i * 137 + 3) % ROWS, (32'h1 << (i % 32)) | (32'(i) * 32'h0101_0101),
                 9'(i * 29 + 1), i[0], 1'b1);
        end
        prog(3, 32'h8000_0001, 9'h155, 1'b1, 1'b1);
        prog(3, 32'h0F00_0000, 9'h0AA, 1'b0, 1'b1);
        rd(8'h18, d); chk("R9 stays unlocked", d[2], 1);

        // R5 R6: sweep all rows with checking on
        wr(8'h00, 32'h8000);
        for (int r = 0; r < ROWS; r++) begin
            read_row(r, v, e);
            chk($sformatf("R5 R6 row %0d", r), {v, e}, {model[r], ^model[r]});
        end
        // R6: check disabled gives no flag
        wr(8'h00, 32'h8200);
        for (int i = 0; i < 8; i++) begin
            read_row((i * 137 + 3) % ROWS, v, e);
            chk("R6 check off", e, 0);
        end
        // R8 R10: reads relocked; program now has no effect
        rd(8'h18, d); chk("R8 read relocks", d[2], 0);
        prog(100, 32'hFFFF_FFFF, 9'h1FF, 1'b1, 1'b0);
        read_row(100, v, e); chk("R10 relocked program", v, model[100]);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule